// File: doc/BRIEF.md
# Serial-Peripheral EEPROM Slave Front End

This block is the slave side of a four-wire serial memory port. It sits behind chip-select, serial clock, serial data in and a pause input, and drives one serial data output together with its output enable. A system clock oversamples the pins through a two-stage synchroniser. The slave works in both clock-idle-low and clock-idle-high framing: data is taken on the rising serial-clock edge and the output moves on the falling edge. Opcodes, addresses and data all travel most significant bit first.

After chip-select falls, the first byte selects one of six commands: set or clear the write-enable latch, read or write the status byte, read the array, or write a page. The write-enable latch and the status byte live in a separate protection unit. The slave tells that unit what was decoded, shifts out the status byte that unit supplies, and, at a byte-aligned chip-select rise, offers it a finished page. The page arrives with its page number and a byte count, and the unit accepts or refuses it in the same cycle. The nonvolatile array is modelled by a parameterised register array, with an optional known preload. An accepted page is written into it in one cycle.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset `so_oe` is low and none of `wel_set`, `wel_clr`, `sr_wr` or `commit` is asserted.
- R2: Serial data is taken on rising serial-clock edges and `so` changes after falling edges, MSB first, both when the clock idles low and when it idles high.
- R3: An opcode whose upper nibble is 0 and low three bits are 110 pulses `wel_set`; low three bits 100 pulses `wel_clr`; bit 3 is don't care.
- R4: Opcode low bits 101 (read status) shifts out `status_i` MSB first, repeating it for every further byte while chip-select stays low.
- R5: Opcode low bits 011 (read) takes a 16-bit address, ignores the bits at and above MEM_AW, returns the byte at that address, and advances one address per byte, rolling from the top address to 0.
- R6: Opcode low bits 010 (write) takes a 16-bit address. The bytes that follow land at successive offsets inside one PAGE_BYTES page, and past the page end they wrap to offset 0 of the same page. A chip-select rise right after a complete byte pulses `commit` once, with `commit_page` equal to the page number and `commit_cnt` equal to the byte total saturated at PAGE_BYTES. With `commit_ok` high, exactly the received offsets are updated.
- R7: A chip-select rise in the middle of a write data byte gives no `commit` and leaves the array unchanged.
- R8: A commit seen with `commit_ok` low leaves the array unchanged.
- R9: Opcode low bits 001 (write status) followed by one byte and a byte-aligned chip-select rise pulses `sr_wr` with `sr_data` equal to that byte; a rise off a byte boundary gives no pulse.
- R10: Any other opcode keeps `so_oe` low and raises no request until the next chip-select fall, after which the next command works normally.
- R11: `hold_n` low while the serial clock is low pauses the slave: `so_oe` goes low and clock edges and input data are ignored. `hold_n` high while the clock is low resumes at the same bit.
- R12: While chip-select is high, `so_oe` stays low and clock and data activity raises no request.
- R13: With PRELOAD set, reset leaves byte a of the array equal to (7*a + 3) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| status_i | input | 8 | Status byte supplied by the protection unit |
| wel_set | output | 1 | Pulse: set-write-enable decoded |
| wel_clr | output | 1 | Pulse: clear-write-enable decoded |
| sr_wr | output | 1 | Pulse: status write offered at chip-select rise |
| sr_data | output | 8 | Status byte offered with `sr_wr` |
| commit | output | 1 | Pulse: finished page offered at chip-select rise |
| commit_page | output | MEM_AW-log2(PAGE_BYTES) | Page number of the offered page |
| commit_cnt | output | log2(PAGE_BYTES+1) | Data bytes received, saturated at PAGE_BYTES |
| commit_ok | input | 1 | Same-cycle acceptance from the protection unit |

## Verification
The bench builds the slave with MEM_AW = 6 and PAGE_BYTES = 8, with preload on, so the array is 64 bytes in eight pages. With these values a single read run crosses the whole array and its rollover. Ten data bytes are enough to wrap a page and to saturate the count, and the scoreboard can predict every byte from the preload formula after each commit. These values also keep the 16-bit address carrying ten ignored upper bits, which lets the bench test address truncation with arbitrary high bytes.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   typedef enum logic [2:0] {
      PH_OP, PH_ADDR, PH_WDATA, PH_SRIN, PH_SRDONE, PH_OUT, PH_MUTE
   } phase_t;

   typedef enum logic [2:0] {
      CMD_SETWE, CMD_CLRWE, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE, CMD_BAD
   } cmd_t;

   // key = {opcode[7:4], opcode[2:0]}; opcode bit 3 never matters
   function automatic cmd_t decode_cmd(input logic [6:0] key);
      if (key[6:3] != 4'd0) return CMD_BAD;
      case (key[2:0])
         3'b110:  return CMD_SETWE;
         3'b100:  return CMD_CLRWE;
         3'b101:  return CMD_RDSR;
         3'b001:  return CMD_WRSR;
         3'b011:  return CMD_READ;
         3'b010:  return CMD_WRITE;
         default: return CMD_BAD;
      endcase
   endfunction

endpackage

// File: rtl/spi_ee_pinsync.sv
module spi_ee_pinsync #(
   parameter int          N   = 4,
   parameter logic [N-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [N-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= RST;
         q    <= RST;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
   parameter int PAGE_BYTES = 128,
   localparam int PW = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    wr_en,
   input  logic [PW-1:0]           wr_off,
   input  logic [7:0]              wr_byte,
   output logic [PAGE_BYTES*8-1:0] data,
   output logic [PAGE_BYTES-1:0]   valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= '0;
      end else if (clear) begin
         valid <= '0;
      end else if (wr_en) begin
         data[wr_off*8 +: 8] <= wr_byte;
         valid[wr_off]       <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
   parameter int MEM_AW     = 10,
   parameter int PAGE_BYTES = 128,
   parameter bit PRELOAD    = 1'b1,
   localparam int PW    = $clog2(PAGE_BYTES),
   localparam int NPW   = MEM_AW - PW,
   localparam int DEPTH = 1 << MEM_AW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [MEM_AW-1:0]       rd_addr,
   output logic [7:0]              rd_data,
   input  logic                    wr_en,
   input  logic [NPW-1:0]          wr_page,
   input  logic [PAGE_BYTES*8-1:0] wr_data,
   input  logic [PAGE_BYTES-1:0]   wr_valid
);
   logic [7:0] mem      [DEPTH];
   logic [7:0] init_val [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_init
      if (PRELOAD) begin : g_pattern
         assign init_val[w] = 8'((w * 7 + 3) % 256);
      end else begin : g_blank
         assign init_val[w] = 8'h00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) mem[w] <= init_val[w];
      end else if (wr_en) begin
         for (int w = 0; w < DEPTH; w++)
            if ((w >> PW) == int'(wr_page) && wr_valid[w % PAGE_BYTES])
               mem[w] <= wr_data[(w % PAGE_BYTES)*8 +: 8];
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int MEM_AW     = 10,
   parameter int PAGE_BYTES = 128,
   parameter bit PRELOAD    = 1'b1,
   localparam int PW  = $clog2(PAGE_BYTES),
   localparam int NPW = MEM_AW - PW,
   localparam int CW  = $clog2(PAGE_BYTES + 1),
   localparam int AB  = $clog2(ADDR_W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic           sck,
   input  logic           si,
   input  logic           hold_n,
   output logic           so,
   output logic           so_oe,
   input  logic [7:0]     status_i,
   output logic           wel_set,
   output logic           wel_clr,
   output logic           sr_wr,
   output logic [7:0]     sr_data,
   output logic           commit,
   output logic [NPW-1:0] commit_page,
   output logic [CW-1:0]  commit_cnt,
   input  logic           commit_ok
);
   if ((1 << PW) != PAGE_BYTES || PAGE_BYTES < 2) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (MEM_AW <= PW) begin : g_bad_depth
      $error("MEM_AW must exceed log2(PAGE_BYTES)");
   end
   if (ADDR_W <= MEM_AW || (ADDR_W % 8) != 0) begin : g_bad_addr
      $error("ADDR_W must be whole bytes and wider than MEM_AW");
   end

   logic [3:0] pin_q;
   logic cs_q, sck_q, si_q, hold_q, cs_d, sck_d, paused;

   spi_ee_pinsync #(.N(4), .RST(4'b1001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si, hold_n}), .q(pin_q));
   assign {cs_q, sck_q, si_q, hold_q} = pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sck_d  <= 1'b0;
         paused <= 1'b0;
      end else begin
         cs_d  <= cs_q;
         sck_d <= sck_q;
         if (cs_q)        paused <= 1'b0;
         else if (!sck_q) paused <= !hold_q;
      end
   end

   logic act, sck_rise, sck_fall, cs_fall, cs_rise;
   assign act      = !cs_q && !paused;
   assign sck_rise = act && sck_q && !sck_d;
   assign sck_fall = act && !sck_q && sck_d;
   assign cs_fall  = !cs_q && cs_d;
   assign cs_rise  = cs_q && !cs_d;

   phase_t              phase;
   logic [2:0]          bitcnt;
   logic [AB-1:0]       abits;
   logic [ADDR_W-1:0]   shreg, shin;
   logic                is_read, so_r, oe_r;
   logic [MEM_AW-1:0]   rd_addr;
   logic [NPW-1:0]      pg_base;
   logic [PW-1:0]       pg_off;
   logic [CW-1:0]       byte_cnt;
   logic [7:0]          sr_byte, mem_rd, src;
   logic [6:0]          out_sh;
   cmd_t                cmd;
   logic                byte_done, buf_wr, unused_bits;

   assign shin        = {shreg[ADDR_W-2:0], si_q};
   assign cmd         = decode_cmd({shin[7:4], shin[2:0]});
   assign byte_done   = sck_rise && bitcnt == 3'd7;
   assign buf_wr      = byte_done && phase == PH_WDATA;
   assign src         = is_read ? mem_rd : status_i;
   assign unused_bits = ^{shreg[ADDR_W-1], shin[ADDR_W-1:MEM_AW]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_MUTE;
         bitcnt   <= '0;
         abits    <= '0;
         shreg    <= '0;
         is_read  <= 1'b0;
         rd_addr  <= '0;
         pg_base  <= '0;
         pg_off   <= '0;
         byte_cnt <= '0;
         sr_byte  <= '0;
         out_sh   <= '0;
         so_r     <= 1'b0;
         oe_r     <= 1'b0;
      end else if (cs_fall) begin
         phase    <= PH_OP;
         bitcnt   <= '0;
         abits    <= '0;
         byte_cnt <= '0;
         oe_r     <= 1'b0;
      end else begin
         if (sck_rise && phase != PH_MUTE) begin
            shreg  <= shin;
            bitcnt <= bitcnt + 3'd1;
            case (phase)
               PH_OP: if (bitcnt == 3'd7) begin
                  case (cmd)
                     CMD_RDSR:  begin phase <= PH_OUT;  is_read <= 1'b0; end
                     CMD_READ:  begin phase <= PH_ADDR; is_read <= 1'b1; end
                     CMD_WRITE: begin phase <= PH_ADDR; is_read <= 1'b0; end
                     CMD_WRSR:  phase <= PH_SRIN;
                     default:   phase <= PH_MUTE;
                  endcase
               end
               PH_ADDR: begin
                  abits <= abits + AB'(1);
                  if (abits == AB'(ADDR_W - 1)) begin
                     if (is_read) begin
                        rd_addr <= shin[MEM_AW-1:0];
                        phase   <= PH_OUT;
                     end else begin
                        pg_base <= shin[MEM_AW-1:PW];
                        pg_off  <= shin[PW-1:0];
                        phase   <= PH_WDATA;
                     end
                  end
               end
               PH_WDATA: if (bitcnt == 3'd7) begin
                  pg_off <= pg_off + PW'(1);
                  if (byte_cnt != CW'(PAGE_BYTES)) byte_cnt <= byte_cnt + CW'(1);
               end
               PH_SRIN: if (bitcnt == 3'd7) begin
                  sr_byte <= shin[7:0];
                  phase   <= PH_SRDONE;
               end
               default: ;
            endcase
         end
         if (sck_fall && phase == PH_OUT) begin
            if (bitcnt == 3'd0) begin
               so_r   <= src[7];
               out_sh <= src[6:0];
               oe_r   <= 1'b1;
               if (is_read) rd_addr <= rd_addr + MEM_AW'(1);
            end else begin
               so_r   <= out_sh[6];
               out_sh <= {out_sh[5:0], 1'b0};
            end
         end
      end
   end

   logic [PAGE_BYTES*8-1:0] buf_data;
   logic [PAGE_BYTES-1:0]   buf_valid;

   spi_ee_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
      .clk(clk), .rst_n(rst_n), .clear(cs_fall), .wr_en(buf_wr),
      .wr_off(pg_off), .wr_byte(shin[7:0]), .data(buf_data), .valid(buf_valid));

   spi_ee_array #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES), .PRELOAD(PRELOAD)) u_mem (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(mem_rd),
      .wr_en(commit && commit_ok), .wr_page(pg_base),
      .wr_data(buf_data), .wr_valid(buf_valid));

   assign wel_set     = byte_done && phase == PH_OP && cmd == CMD_SETWE;
   assign wel_clr     = byte_done && phase == PH_OP && cmd == CMD_CLRWE;
   assign sr_wr       = cs_rise && phase == PH_SRDONE && bitcnt == 3'd0;
   assign sr_data     = sr_byte;
   assign commit      = cs_rise && phase == PH_WDATA && bitcnt == 3'd0 && byte_cnt != '0;
   assign commit_page = pg_base;
   assign commit_cnt  = byte_cnt;
   assign so          = so_r;
   assign so_oe       = oe_r && !paused && !cs_q && phase == PH_OUT;
endmodule

// File: rtl/spi_ee_slave_chk.sv
module spi_ee_slave_chk #(
   parameter int CW         = 8,
   parameter int PAGE_BYTES = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_q,
   input logic          paused,
   input logic          so_oe,
   input logic          wel_set,
   input logic          wel_clr,
   input logic          sr_wr,
   input logic          commit,
   input logic [CW-1:0] commit_cnt
);
   // R12
   so_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> !cs_q);

   // R11
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> !so_oe);

   // R6
   commit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (commit_cnt != '0 && commit_cnt <= CW'(PAGE_BYTES)));

   // R6
   commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

   // R3
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wel_set, wel_clr, sr_wr, commit}));

   // R9
   sr_after_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr |-> cs_q);
endmodule

bind spi_ee_slave spi_ee_slave_chk #(.CW(CW), .PAGE_BYTES(PAGE_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .paused(paused), .so_oe(so_oe),
   .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr), .commit(commit),
   .commit_cnt(commit_cnt));

// File: tb/spi_ee_slave_test.sv
module spi_ee_slave_test;
   localparam int MAW  = 6;
   localparam int PB   = 8;
   localparam int NPW  = 3;
   localparam int CW   = 4;
   localparam int SIZE = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, allow = 1'b1;
   logic [7:0] stat_in = 8'h5A;
   logic so, so_oe, wel_set, wel_clr, sr_wr, commit;
   logic [7:0] sr_data;
   logic [NPW-1:0] commit_page;
   logic [CW-1:0] commit_cnt;
   wire so_pin = so_oe ? so : 1'bz;

   spi_ee_slave #(.ADDR_W(16), .MEM_AW(MAW), .PAGE_BYTES(PB), .PRELOAD(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .status_i(stat_in), .wel_set(wel_set),
      .wel_clr(wel_clr), .sr_wr(sr_wr), .sr_data(sr_data), .commit(commit),
      .commit_page(commit_page), .commit_cnt(commit_cnt), .commit_ok(allow));

   int n_chk = 0, n_bad = 0, cyc = 0;
   int n_set = 0, n_clr = 0, n_sr = 0, n_commit = 0, n_oe = 0;
   int last_cnt = 0, last_page = 0;
   logic [7:0] last_sr = 8'h00;
   logic [7:0] exp_mem [SIZE];
   bit mode3 = 1'b0;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (wel_set) n_set <= n_set + 1;
         if (wel_clr) n_clr <= n_clr + 1;
         if (so_oe)   n_oe  <= n_oe + 1;
         if (sr_wr) begin n_sr <= n_sr + 1; last_sr <= sr_data; end
         if (commit) begin
            n_commit  <= n_commit + 1;
            last_cnt  <= int'(commit_cnt);
            last_page <= int'(commit_page);
         end
      end
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got %0d expected < 150000 cycles", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   task automatic sel();
      sck = mode3;
      half();
      cs_n = 1'b0;
      half();
   endtask

   task automatic desel();
      half();
      cs_n = 1'b1;
      repeat (3) half();
   endtask

   task automatic xbit(input logic b, output logic r);
      if (mode3) begin
         sck = 1'b0; si = b; half(); r = so_pin; sck = 1'b1; half();
      end else begin
         si = b; half(); r = so_pin; sck = 1'b1; half(); sck = 1'b0;
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         logic r;
         xbit(tx[i], r);
         rx[i] = r;
      end
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] rx;
      xbyte(tx, rx);
   endtask

   task automatic read_run(input logic [15:0] a, input int n, input string rq);
      logic [7:0] rx;
      sel();
      send(8'h03); send(a[15:8]); send(a[7:0]);
      for (int k = 0; k < n; k++) begin
         int idx;
         idx = (int'(a) + k) % SIZE;
         xbyte(8'h00, rx);
         chk(rx === exp_mem[idx], rq, int'(rx), int'(exp_mem[idx]));
      end
      desel();
   endtask

   task automatic page_write(input logic [15:0] a, input int n, input logic [7:0] base);
      sel();
      send(8'h02); send(a[15:8]); send(a[7:0]);
      for (int k = 0; k < n; k++) send(base + 8'(k));
      desel();
      if (allow) begin
         for (int k = 0; k < n; k++) begin
            int idx;
            idx = (int'(a[5:3]) * PB) + ((int'(a[2:0]) + k) % PB);
            exp_mem[idx] = base + 8'(k);
         end
      end
   endtask

   initial begin
      logic [7:0] rx;
      int s0, s1;
      for (int a = 0; a < SIZE; a++) exp_mem[a] = 8'((a * 7 + 3) % 256);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      half();

      // R1: idle after reset
      chk(so_oe == 1'b0, "R1 so_oe", int'(so_oe), 0);
      chk((n_set + n_clr + n_sr + n_commit) == 0, "R1 requests", n_set + n_clr + n_sr + n_commit, 0);

      // R13 R5 R2: sweep whole array in clock-idle-low framing, with rollover
      read_run(16'h0000, SIZE + 2, "R13 R5 R2 sweep mode0");
      // R5: upper address bits ignored, rollover from top
      read_run(16'hABC5, 4, "R5 high bits ignored");
      read_run(16'h003E, 4, "R5 rollover");

      // R4 R2: status read in clock-idle-high framing
      mode3 = 1'b1;
      sel(); send(8'h05);
      xbyte(8'h00, rx); chk(rx === 8'h5A, "R4 R2 status byte 1", int'(rx), 8'h5A);
      xbyte(8'h00, rx); chk(rx === 8'h5A, "R4 status repeat", int'(rx), 8'h5A);
      desel();
      mode3 = 1'b0;

      // R3: write-enable set/clear, bit 3 don't care
      s0 = n_set; s1 = n_clr;
      sel(); send(8'h06); desel();
      sel(); send(8'h0E); desel();
      chk(n_set == s0 + 2, "R3 set pulses", n_set - s0, 2);
      sel(); send(8'h04); desel();
      sel(); send(8'h0C); desel();
      chk(n_clr == s1 + 2, "R3 clear pulses", n_clr - s1, 2);

      // R6: page write that wraps and saturates count
      s0 = n_commit;
      page_write(16'h0013, 10, 8'hC0);
      chk(n_commit == s0 + 1, "R6 one commit", n_commit - s0, 1);
      chk(last_cnt == PB, "R6 saturated count", last_cnt, PB);
      chk(last_page == 2, "R6 page number", last_page, 2);
      // R6: partial write wrapping to offset 0
      page_write(16'h773E, 3, 8'h40);
      chk(last_cnt == 3, "R6 partial count", last_cnt, 3);
      chk(last_page == 7, "R6 partial page", last_page, 7);
      read_run(16'h0000, SIZE, "R6 contents after writes");

      // R7: chip-select rise mid-byte aborts
      s0 = n_commit;
      sel(); send(8'h02); send(8'h00); send(8'h28); send(8'h11);
      for (int i = 0; i < 4; i++) begin logic r; xbit(1'b1, r); end
      desel();
      chk(n_commit == s0, "R7 no commit", n_commit - s0, 0);
      read_run(16'h0028, PB, "R7 page unchanged");

      // R8: refused commit
      allow = 1'b0;
      s0 = n_commit;
      page_write(16'h0030, 2, 8'hEE);
      chk(n_commit == s0 + 1, "R8 commit offered", n_commit - s0, 1);
      allow = 1'b1;
      read_run(16'h0030, PB, "R8 page unchanged");

      // R9: status write, aligned and misaligned
      s0 = n_sr;
      sel(); send(8'h01); send(8'h8C); desel();
      chk(n_sr == s0 + 1, "R9 status write pulse", n_sr - s0, 1);
      chk(last_sr == 8'h8C, "R9 status write data", int'(last_sr), 8'h8C);
      sel(); send(8'h09); send(8'h33);
      for (int i = 0; i < 3; i++) begin logic r; xbit(1'b0, r); end
      desel();
      chk(n_sr == s0 + 1, "R9 misaligned ignored", n_sr - s0, 1);

      // R10: unknown opcodes mute the slave
      s0 = n_oe; s1 = n_set + n_clr + n_sr + n_commit;
      sel(); send(8'h07); send(8'h06); send(8'h00); desel();
      sel(); send(8'h13); send(8'h00); send(8'h05); send(8'h00); desel();
      chk(n_oe == s0, "R10 output stays off", n_oe - s0, 0);
      chk((n_set + n_clr + n_sr + n_commit) == s1, "R10 no requests",
          n_set + n_clr + n_sr + n_commit - s1, 0);
      stat_in = 8'hA3;
      sel(); send(8'h05); xbyte(8'h00, rx); desel();
      chk(rx === 8'hA3, "R10 recovers next frame", int'(rx), 8'hA3);

      // R12: activity while deselected
      s0 = n_oe; s1 = n_set;
      for (int i = 7; i >= 0; i--) begin
         si = 1'(8'h06 >> i); half(); sck = 1'b1; half(); sck = 1'b0;
      end
      half();
      chk(n_oe == s0, "R12 output off", n_oe - s0, 0);
      chk(n_set == s1, "R12 no request", n_set - s1, 0);

      // R11: pause mid-byte during a read
      sel(); send(8'h03); send(8'h00); send(8'h09);
      for (int i = 7; i >= 0; i--) begin
         logic r;
         xbit(1'b0, r);
         rx[i] = r;
         if (i == 4) begin
            hold_n = 1'b0; half();
            chk(so_oe == 1'b0, "R11 paused output off", int'(so_oe), 0);
            for (int t = 0; t < 4; t++) begin sck = ~sck; si = ~si; half(); end
            hold_n = 1'b1; half();
         end
      end
      chk(rx === exp_mem[9], "R11 byte across pause", int'(rx), int'(exp_mem[9]));
      xbyte(8'h00, rx);
      chk(rx === exp_mem[10], "R11 next byte", int'(rx), int'(exp_mem[10]));
      desel();

      // R2 R5: full sweep in clock-idle-high framing
      mode3 = 1'b1;
      read_run(16'h0000, SIZE, "R2 R5 sweep mode3");
      mode3 = 1'b0;

      summary();
   end
endmodule